// File: doc/BRIEF.md
# Multi-Mode SIMD and Complex Multiplier

This block is a pipelined multiplier that accepts one operation per clock. Each operation has two 32-bit operands, a 4-bit mode code and a signed/unsigned flag. It returns a 64-bit result. A single datapath covers four kinds of work. It can do a full-width product or a 16x32 product. It can split the operands into 16-bit or 8-bit lanes, with optional summing or add/subtract. It can multiply packed complex numbers, either at full precision or rounded and saturated into one 32-bit word. It can also multiply byte lanes in GF(2^8).

An operation is presented with `inValid` high. Exactly two clock edges later `outValid` is high for one cycle and `result` carries the answer. Between answers `result` keeps its last value. Packed complex operands hold the real part in bits 31:16 and the imaginary part in bits 15:0.

Top module: `simd_mult_unit`

## Requirements
- R1: An operation sampled with `inValid` high at a clock edge yields `outValid` high after exactly the second following edge, with its result on `result`. When no result is delivered, `result` holds its previous value.
- R2: Mode 0 returns the full 64-bit product `opA*opB`. Both operands are signed when `isSigned`=1 and unsigned otherwise.
- R3: Mode 1 returns the product of `opA[15:0]` and the full `opB`, extended to 64 bits, with the signedness set by `isSigned`. `opA[31:16]` is ignored.
- R4: Mode 2 returns the product of the upper halves in bits 63:32 and the product of the lower halves in bits 31:0. Each product is 32 bits and uses the signedness set by `isSigned`.
- R5: Mode 3 multiplies byte lane i of each operand (i=0 at bits 7:0). It places the 16-bit product at `result[16i+15:16i]`, with the signedness set by `isSigned`.
- R6: Mode 4 returns the sum of the four byte-lane products, extended to 64 bits (sign-extended when `isSigned`=1).
- R7: Mode 5 takes the upper-half product P1 and the lower-half product P0. It returns P1+P0 in bits 63:32 and P1-P0 in bits 31:0, each modulo 2^32.
- R8: Mode 6 is a complex product: real = ar*br - ai*bi in bits 63:32, imag = ar*bi + ai*br in bits 31:0, each modulo 2^32. The 16-bit parts are always signed, whatever `isSigned` says.
- R9: Mode 7 forms the same real and imaginary values. It adds 2^15 to each, shifts right arithmetically by 16 and saturates to [-32768, 32767]. Real goes in bits 31:16, imag in bits 15:0, and bits 63:32 are zero.
- R10: Mode 8 multiplies each byte lane in GF(2^8) with polynomial x^8+x^4+x^3+x^2+1. It places lane i at `result[8i+7:8i]` and sets bits 63:32 to zero.
- R11: Mode codes 9 to 15 produce an all-zero result.
- R12: While `rst_n` is low, `outValid` is 0 and `result` is 0.
- R13: Operations issued on consecutive cycles produce results on consecutive cycles, in issue order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| inValid | input | 1 | Operation present this cycle |
| opMode | input | 4 | Mode code 0 to 15 |
| isSigned | input | 1 | Signed operands for integer modes 0 to 5 |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| outValid | output | 1 | Result present this cycle |
| result | output | 64 | Result word |

## Verification
A mode or signedness flag latched with the wrong operation shows up as a wrong lane layout or wrong sign extension on the very next `outValid`. Back-to-back streams of mixed modes catch this within two cycles. A broken valid stage shows at the ports as a missing, doubled or early `outValid`, which the scoreboard sees as an empty or leftover queue. An enable that fires without a valid operation shows as `result` changing while `outValid` is low, which is checked on every idle cycle.

// File: rtl/simd_mult_pkg.sv
package simd_mult_pkg;
  localparam int DataW  = 32;
  localparam int ResW   = 2 * DataW;
  localparam int HalfW  = DataW / 2;
  localparam int ByteW  = 8;
  localparam int NBytes = DataW / ByteW;
  localparam int NHalf  = DataW / HalfW;
  localparam int ModeW  = 4;
  localparam logic [ByteW-1:0] GfLowPoly = 8'h1D;

  typedef enum logic [ModeW-1:0] {
    MODE_MUL32    = 4'd0,
    MODE_MUL16X32 = 4'd1,
    MODE_DUAL16   = 4'd2,
    MODE_QUAD8    = 4'd3,
    MODE_QUAD8SUM = 4'd4,
    MODE_DUAL16AS = 4'd5,
    MODE_CPLX     = 4'd6,
    MODE_CPLXRND  = 4'd7,
    MODE_GF8      = 4'd8
  } mode_e;

  typedef struct packed {
    logic  capture;
    logic  commit;
    mode_e mode;
    logic  sgn;
  } strobe_t;

  function automatic logic [ByteW-1:0] gfMul8(input logic [ByteW-1:0] x,
                                              input logic [ByteW-1:0] y);
    logic [ByteW-1:0] acc;
    logic [ByteW-1:0] sh;
    acc = '0;
    sh  = x;
    for (int i = 0; i < ByteW; i++) begin
      if (y[i]) acc = acc ^ sh;
      sh = {sh[ByteW-2:0], 1'b0} ^ (sh[ByteW-1] ? GfLowPoly : '0);
    end
    return acc;
  endfunction

  function automatic logic [HalfW-1:0] rndSat(input logic signed [DataW:0] x);
    logic signed [DataW+1:0] t;
    logic [HalfW-1:0] r;
    t = x + 34'sd32768;
    if (!t[DataW+1] && (t[DataW:DataW-1] != 2'b00))
      r = 16'h7FFF;
    else if (t[DataW+1] && (t[DataW:DataW-1] != 2'b11))
      r = 16'h8000;
    else
      r = t[DataW-1:HalfW];
    return r;
  endfunction
endpackage

// File: rtl/simd_mult_ctrl.sv
module simd_mult_ctrl
  import simd_mult_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic [ModeW-1:0] opMode,
  input  logic             isSigned,
  output strobe_t          strb,
  output logic             outValid
);
  logic  stage1Valid;
  mode_e mode1;
  logic  sgn1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1Valid <= 1'b0;
      outValid    <= 1'b0;
      mode1       <= MODE_MUL32;
      sgn1        <= 1'b0;
    end else begin
      stage1Valid <= inValid;
      outValid    <= stage1Valid;
      if (inValid) begin
        mode1 <= mode_e'(opMode);
        sgn1  <= isSigned;
      end
    end
  end

  assign strb = '{capture: inValid, commit: stage1Valid, mode: mode1, sgn: sgn1};

  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |-> ##2 outValid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |-> ##2 !outValid);
  a_r13_one_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && $past(inValid)) |-> ##2 (outValid && $past(outValid)));
endmodule

// File: rtl/simd_mult_dp.sv
module simd_mult_dp
  import simd_mult_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          strb,
  input  logic [DataW-1:0] opA,
  input  logic [DataW-1:0] opB,
  output logic [ResW-1:0]  result
);
  logic [DataW-1:0] aR, bR;
  logic             s;
  logic [ResW-1:0]  nextRes;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aR <= '0;
      bR <= '0;
    end else if (strb.capture) begin
      aR <= opA;
      bR <= opB;
    end
  end

  assign s = strb.sgn;

  // full and mixed-width products
  logic signed [DataW:0]     a33, b33;
  logic signed [HalfW:0]     aLo17;
  logic signed [ResW-1:0]    pFull;
  logic signed [HalfW+DataW-1:0] pMix;
  assign a33   = $signed({s & aR[DataW-1], aR});
  assign b33   = $signed({s & bR[DataW-1], bR});
  assign aLo17 = $signed({s & aR[HalfW-1], aR[HalfW-1:0]});
  assign pFull = a33 * b33;
  assign pMix  = aLo17 * b33;

  // half-word lanes: integer (signedness selectable) and complex (always signed)
  logic signed [DataW-1:0] pHalf [NHalf];
  logic signed [HalfW-1:0] cA [NHalf];
  logic signed [HalfW-1:0] cB [NHalf];
  for (genvar h = 0; h < NHalf; h++) begin : g_half
    logic signed [HalfW:0] ha, hb;
    assign ha = $signed({s & aR[h*HalfW+HalfW-1], aR[h*HalfW +: HalfW]});
    assign hb = $signed({s & bR[h*HalfW+HalfW-1], bR[h*HalfW +: HalfW]});
    assign pHalf[h] = ha * hb;
    assign cA[h] = $signed(aR[h*HalfW +: HalfW]);
    assign cB[h] = $signed(bR[h*HalfW +: HalfW]);
  end

  // byte lanes: integer products and GF(2^8) products
  logic signed [2*ByteW-1:0] pByte [NBytes];
  logic [ByteW-1:0]          gfLane [NBytes];
  logic [2*ByteW+1:0]        byteExt [NBytes];
  for (genvar i = 0; i < NBytes; i++) begin : g_byte
    logic signed [ByteW:0] ba, bb;
    assign ba = $signed({s & aR[i*ByteW+ByteW-1], aR[i*ByteW +: ByteW]});
    assign bb = $signed({s & bR[i*ByteW+ByteW-1], bR[i*ByteW +: ByteW]});
    assign pByte[i]   = ba * bb;
    assign byteExt[i] = {{2{s & pByte[i][2*ByteW-1]}}, pByte[i]};
    assign gfLane[i]  = gfMul8(aR[i*ByteW +: ByteW], bR[i*ByteW +: ByteW]);
  end

  logic [2*ByteW+1:0] qSum;
  assign qSum = byteExt[0] + byteExt[1] + byteExt[2] + byteExt[3];

  logic [DataW-1:0] dSum, dDiff;
  assign dSum  = pHalf[1] + pHalf[0];
  assign dDiff = pHalf[1] - pHalf[0];

  // complex: index 1 = real half, index 0 = imaginary half
  logic signed [DataW-1:0] pRr, pIi, pRi, pIr;
  logic signed [DataW:0]   cReal, cImag;
  assign pRr   = cA[1] * cB[1];
  assign pIi   = cA[0] * cB[0];
  assign pRi   = cA[1] * cB[0];
  assign pIr   = cA[0] * cB[1];
  assign cReal = pRr - pIi;
  assign cImag = pRi + pIr;

  always_comb begin
    unique case (strb.mode)
      MODE_MUL32:    nextRes = pFull;
      MODE_MUL16X32: nextRes = {{(ResW-HalfW-DataW){s & pMix[HalfW+DataW-1]}}, pMix};
      MODE_DUAL16:   nextRes = {pHalf[1], pHalf[0]};
      MODE_QUAD8:    nextRes = {pByte[3], pByte[2], pByte[1], pByte[0]};
      MODE_QUAD8SUM: nextRes = {{(ResW-2*ByteW-2){s & qSum[2*ByteW+1]}}, qSum};
      MODE_DUAL16AS: nextRes = {dSum, dDiff};
      MODE_CPLX:     nextRes = {cReal[DataW-1:0], cImag[DataW-1:0]};
      MODE_CPLXRND:  nextRes = {{DataW{1'b0}}, rndSat(cReal), rndSat(cImag)};
      MODE_GF8:      nextRes = {{DataW{1'b0}}, gfLane[3], gfLane[2], gfLane[1], gfLane[0]};
      default:       nextRes = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) result <= '0;
    else if (strb.commit) result <= nextRes;
  end

  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.commit |=> $stable(result));
  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.commit && strb.mode == MODE_CPLXRND) |=> (result[ResW-1:DataW] == '0));
  a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.commit && strb.mode == MODE_GF8) |=> (result[ResW-1:DataW] == '0));
  a_r11_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.commit && strb.mode > MODE_GF8) |=> (result == '0));
endmodule

// File: rtl/simd_mult_unit.sv
module simd_mult_unit
  import simd_mult_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic [3:0]  opMode,
  input  logic        isSigned,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  output logic        outValid,
  output logic [63:0] result
);
  strobe_t strb;

  simd_mult_ctrl uCtrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .opMode   (opMode),
    .isSigned (isSigned),
    .strb     (strb),
    .outValid (outValid)
  );

  simd_mult_dp uDp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb   (strb),
    .opA    (opA),
    .opB    (opB),
    .result (result)
  );
endmodule

// File: tb/sim_simd_mult_unit.sv
`timescale 1ns/1ps
module sim_simd_mult_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [3:0]  opMode = '0;
  logic        isSigned = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        outValid;
  logic [63:0] result;

  int testCount = 0;
  int failCount = 0;
  bit monOn = 1'b0;
  bit haveLast = 1'b0;
  logic [63:0] lastRes = '0;

  typedef struct {
    logic [63:0] val;
    string       tag;
  } exp_t;
  exp_t scoreQ[$];

  always #10 clk = ~clk;

  simd_mult_unit u0 (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .opMode(opMode),
    .isSigned(isSigned), .opA(opA), .opB(opB),
    .outValid(outValid), .result(result)
  );

  function automatic longint sx(logic [31:0] v, int w, bit sg);
    longint x;
    x = longint'({32'd0, v}) & ((longint'(1) << w) - 1);
    if (sg && v[w-1]) x = x - (longint'(1) << w);
    return x;
  endfunction

  function automatic logic [7:0] gfRef(logic [7:0] x, logic [7:0] y);
    logic [14:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (y[i]) p = p ^ (15'(x) << i);
    for (int k = 14; k >= 8; k--) if (p[k]) p = p ^ (15'h11D << (k - 8));
    return p[7:0];
  endfunction

  function automatic logic [15:0] rsRef(longint x);
    longint y;
    y = (x + 32768) >>> 16;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    return y[15:0];
  endfunction

  function automatic logic [63:0] model(int m, bit sg, logic [31:0] a, logic [31:0] b);
    longint hi, lo, re, im, sum;
    logic [63:0] r;
    r = '0;
    case (m)
      0: r = sx(a, 32, sg) * sx(b, 32, sg);
      1: r = sx(a, 16, sg) * sx(b, 32, sg);
      2, 5: begin
        hi = sx(a >> 16, 16, sg) * sx(b >> 16, 16, sg);
        lo = sx(a, 16, sg) * sx(b, 16, sg);
        if (m == 2) r = {hi[31:0], lo[31:0]};
        else begin
          sum = hi + lo;
          re  = hi - lo;
          r = {sum[31:0], re[31:0]};
        end
      end
      3, 4: begin
        sum = 0;
        for (int i = 0; i < 4; i++) begin
          hi = sx(a >> (8*i), 8, sg) * sx(b >> (8*i), 8, sg);
          r[16*i +: 16] = hi[15:0];
          sum += hi;
        end
        if (m == 4) r = sum;
      end
      6, 7: begin
        re = sx(a >> 16, 16, 1) * sx(b >> 16, 16, 1) - sx(a, 16, 1) * sx(b, 16, 1);
        im = sx(a >> 16, 16, 1) * sx(b, 16, 1) + sx(a, 16, 1) * sx(b >> 16, 16, 1);
        if (m == 6) r = {re[31:0], im[31:0]};
        else r = {32'd0, rsRef(re), rsRef(im)};
      end
      8: for (int i = 0; i < 4; i++) r[8*i +: 8] = gfRef(a[8*i +: 8], b[8*i +: 8]);
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] expv);
    testCount++;
    if (act !== expv) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic send(int m, bit sg, logic [31:0] a, logic [31:0] b, string tag);
    exp_t e;
    @(negedge clk);
    inValid = 1'b1; opMode = 4'(m); isSigned = sg; opA = a; opB = b;
    e.val = model(m, sg, a, b);
    e.tag = tag;
    scoreQ.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0; opA = $urandom; opB = $urandom; opMode = 4'($urandom);
    end
  endtask

  // monitor: pops on every delivered result, checks hold on idle cycles (R1, R13)
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (monOn) begin
        if (outValid) begin
          if (scoreQ.size() == 0) begin
            check("R1 unexpected outValid", {63'd0, outValid}, 64'd0);
          end else begin
            e = scoreQ.pop_front();
            check(e.tag, result, e.val);
          end
          lastRes = result;
          haveLast = 1'b1;
        end else if (haveLast) begin
          check("R1 hold while idle", result, lastRes);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    // R12: reset state, with active stimulus present
    inValid = 1'b1; opA = 32'hFFFF_FFFF; opB = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R12 outValid in reset", {63'd0, outValid}, 64'd0);
    check("R12 result in reset", result, 64'd0);
    inValid = 1'b0;
    rst_n = 1'b1;
    monOn = 1'b1;

    // R1: single op, exact latency
    send(0, 1, 32'd7, 32'd6, "R1 single op");
    idle(1);
    check("R1 not early", {63'd0, outValid}, 64'd0);
    @(negedge clk);
    idle(3);

    // R13: back-to-back stream of mixed modes
    send(0, 1, 32'hFFFF_FFFF, 32'h0000_0002, "R2 signed -1*2");
    send(0, 0, 32'hFFFF_FFFF, 32'h0000_0002, "R2 unsigned");
    send(0, 1, 32'h8000_0000, 32'h8000_0000, "R2 min*min");
    send(1, 1, 32'hABCD_FFFF, 32'h1234_5678, "R3 signed, upper a ignored");
    send(1, 0, 32'h0000_FFFF, 32'hFFFF_FFFF, "R3 unsigned max");
    send(2, 1, 32'h8000_7FFF, 32'h8000_7FFF, "R4 signed");
    send(2, 0, 32'h8000_7FFF, 32'hFFFF_0003, "R4 unsigned");
    send(3, 1, 32'h80FF_017F, 32'h80FF_02FF, "R5 signed");
    send(3, 0, 32'h80FF_017F, 32'h80FF_02FF, "R5 unsigned");
    send(4, 1, 32'h80FF_017F, 32'h80FF_02FF, "R6 signed sum");
    send(4, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6 unsigned max sum");
    send(4, 1, 32'h8080_8080, 32'h8080_8080, "R6 signed max sum");
    send(5, 1, 32'h7FFF_8000, 32'h7FFF_7FFF, "R7 signed");
    send(5, 0, 32'h0002_FFFF, 32'h0003_FFFF, "R7 unsigned wrap");
    idle(2);
    send(6, 1, 32'h0003_0004, 32'h0001_0002, "R8 small");
    send(6, 0, 32'hFFFD_0004, 32'h0001_FFFE, "R8 signed regardless of flag");
    send(6, 1, 32'h8000_8000, 32'h8000_7FFF, "R8 extreme");
    send(7, 1, 32'h8000_8000, 32'h8000_7FFF, "R9 positive saturation");
    send(7, 0, 32'h4000_C000, 32'h2000_1000, "R9 ordinary");
    send(7, 1, 32'h0001_0000, 32'h8000_0000, "R9 round tie");
    send(7, 1, 32'h8000_0000, 32'h7FFF_0000, "R9 negative");
    send(8, 0, 32'h0253_8001, 32'h80CA_02FF, "R10 gf lanes");
    send(8, 1, 32'hFFFF_FFFF, 32'hFF02_0180, "R10 gf high");
    send(9, 1, 32'h1234_5678, 32'h9ABC_DEF0, "R11 code 9");
    send(15, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R11 code 15");
    idle(4);
    for (int i = 0; i < 40; i++)
      send(i % 12, i[0], $urandom, $urandom, "R13 mixed stream");
    idle(6);
    check("R13 queue drained", 64'(scoreQ.size()), 64'd0);
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule